// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a clocked request stream to an external asynchronous static RAM with a 17-bit address and 8-bit data. Each accepted request becomes one complete memory access. For a read, the block drives the address and the strobes and then waits a fixed number of clock cycles. It then captures the byte on the data pins and returns it as a one-cycle response. For a write, the block first keeps the data bus idle long enough for the memory's output drivers to release it. It then drives the data and lowers write enable for the required pulse width, and finally raises write enable while it still holds address and data for one more cycle. Every window is a cycle count. Each count is the ceiling of the nanosecond figure, given as a parameter, divided by the clock period, with a minimum of one cycle.

The memory has two chip selects of opposite sense: `mem_ce_n` is active low and `mem_ce` is active high. It is selected only when both are active. The block deselects it after reset and whenever `stby_req` is high. An access already in progress always finishes before the block deselects. After a deselected period, the block keeps the memory deselected for one read-cycle time before it accepts the next request.

The request side uses a valid/ready handshake with back-pressure. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. Once the master raises `req_valid`, it must hold the request fields stable until that transfer. `req_ready` is high only while the block is idle and standby is not requested, so it is low for the whole of an access. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the consumer must take `rsp_data` in that cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and afterwards, until the recovery window has passed, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=0 and `rsp_valid`=0. With the default parameters, `req_ready` first reads high 3 cycles after reset is released.
- R2: `req_ready` is high only while no access is in progress. While it is high, write enable and output enable are both inactive and the data drivers are off.
- R3: A read keeps the memory selected with `mem_oe_n`=0 and `mem_we_n`=1 for RD cycles. RD is the largest of ceil(45 ns), ceil(20 ns) and ceil(45 ns) divided by the clock period, which is 3 at 20 ns. `rsp_valid` rises on the RD-th edge after the accepting edge.
- R4: A write spends HZ cycles selected with both strobes inactive and the drivers off (HZ = ceil(15 ns/period), which is 1). It then spends WR cycles with `mem_we_n`=0 and the data driven (WR = the largest of the ceilings of 35, 35, 25 and 45 ns, which is 3). It then spends one cycle with `mem_we_n`=1 and the data still driven. `req_ready` returns HZ+WR+1 edges after the accepting edge.
- R5: The block never drives the data bus while output enable is low. It turns its drivers on only after output enable has been high for at least HZ cycles.
- R6: Write enable is low only while the memory is selected, output enable is high and the data drivers are on.
- R7: Address and drive data stay constant for as long as an access is driving them.
- R8: While `stby_req` is high, `req_ready` is low. From the cycle after standby is requested in idle, the memory is deselected. A request waiting during standby causes no memory activity.
- R9: If standby is requested during an access, that access completes, and a write has been stored, before the memory is deselected.
- R10: After `stby_req` falls, the memory stays deselected for RC cycles (ceil(45 ns/period), which is 3). `req_ready` rises RC+1 edges after the release.
- R11: `rsp_valid` is high for exactly one cycle per read.
- R12: A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_req | input | 1 | Request to deselect the memory (standby) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read byte |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 8 | Data from the memory pins |

## Verification
The bound checker watches the pin-level safety rules on every cycle. It checks that the block never drives the bus against output enable and that the write overlap occurs only while selected with drivers on. It also checks the minimum read, write-pulse, turnaround and recovery windows using counters, and that address and data hold steady during an access. Only the bench's scenarios can show the rest. Those are the exact latencies, data landing at the right address through a memory model that returns garbage when a read is too short, standby entry waiting for an in-flight write, and a request held across standby and then served.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    SQ_RECOV,
    SQ_IDLE,
    SQ_READ,
    SQ_TURN,
    SQ_PULSE,
    SQ_HOLD,
    SQ_STBY
  } seq_t;

  // Internal active-high view of the memory strobes
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drv;
  } pin_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_t pins_of(input seq_t s);
    pin_t p;
    p = '0;
    case (s)
      SQ_IDLE:  p.sel = 1'b1;
      SQ_READ:  begin p.sel = 1'b1; p.oe = 1'b1; end
      SQ_TURN:  p.sel = 1'b1;
      SQ_PULSE: begin p.sel = 1'b1; p.we = 1'b1; p.drv = 1'b1; end
      SQ_HOLD:  begin p.sel = 1'b1; p.drv = 1'b1; end
      default:  p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/1ps
module sram_wait_cnt #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= INIT;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_pin_regs.sv
`timescale 1ns/1ps
module sram_pin_regs
  import sram_ctl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pin_t          pins_nxt,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= ~pins_nxt.sel;
      mem_ce    <=  pins_nxt.sel;
      mem_oe_n  <= ~pins_nxt.oe;
      mem_we_n  <= ~pins_nxt.we;
      mem_dq_oe <=  pins_nxt.drv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (capture) begin
      mem_addr <= addr_in;
      mem_dq_o <= data_in;
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] pin_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_data <= pin_data;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_NS    = 20,
  parameter int T_AA_NS   = 45,
  parameter int T_OE_NS   = 20,
  parameter int T_RC_NS   = 45,
  parameter int T_WC_NS   = 45,
  parameter int T_PWE_NS  = 35,
  parameter int T_AW_NS   = 35,
  parameter int T_SD_NS   = 25,
  parameter int T_HZ_NS   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby_req,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int RD_CYC = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                               ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int WR_CYC = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                               imax(ns_to_cyc(T_SD_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS)));
  localparam int HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int RC_CYC = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WR_CYC), imax(HZ_CYC, RC_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);

  seq_t         state, state_nxt;
  logic         cnt_load, cnt_zero, accept, take;
  logic [CW-1:0] cnt_val;
  pin_t         pins_nxt;

  assign req_ready = (state == SQ_IDLE) && !stby_req;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    take      = 1'b0;
    case (state)
      SQ_RECOV: if (cnt_zero) state_nxt = SQ_IDLE;
      SQ_IDLE: begin
        if (stby_req) begin
          state_nxt = SQ_STBY;
        end else if (accept) begin
          cnt_load = 1'b1;
          if (req_write) begin
            state_nxt = SQ_TURN;
            cnt_val   = CW'(HZ_CYC - 1);
          end else begin
            state_nxt = SQ_READ;
            cnt_val   = CW'(RD_CYC - 1);
          end
        end
      end
      SQ_READ: if (cnt_zero) begin
        take      = 1'b1;
        state_nxt = SQ_IDLE;
      end
      SQ_TURN: if (cnt_zero) begin
        state_nxt = SQ_PULSE;
        cnt_load  = 1'b1;
        cnt_val   = CW'(WR_CYC - 1);
      end
      SQ_PULSE: if (cnt_zero) state_nxt = SQ_HOLD;
      SQ_HOLD:  state_nxt = SQ_IDLE;
      SQ_STBY: if (!stby_req) begin
        state_nxt = SQ_RECOV;
        cnt_load  = 1'b1;
        cnt_val   = CW'(RC_CYC - 1);
      end
      default: state_nxt = SQ_RECOV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_RECOV;
    else        state <= state_nxt;
  end

  assign pins_nxt = pins_of(state_nxt);

  sram_wait_cnt #(.W(CW), .INIT(CW'(RC_CYC - 1))) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  sram_pin_regs #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins_nxt(pins_nxt), .capture(accept),
    .addr_in(req_addr), .data_in(req_wdata),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .pin_data(mem_dq_i),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/sram_async_chk.sv
`timescale 1ns/1ps
module sram_async_chk #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int RD_CYC = 3,
  parameter int WR_CYC = 3,
  parameter int HZ_CYC = 1,
  parameter int RC_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stby_req,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe
);
  logic [7:0] oe_lo_run, oe_hi_run, we_lo_run, desel_run;
  logic       selected, busy;

  assign selected = !mem_ce_n && mem_ce;
  assign busy     = !mem_oe_n || mem_dq_oe;

  function automatic logic [7:0] bump(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_lo_run <= '0; oe_hi_run <= '0; we_lo_run <= '0; desel_run <= '0;
    end else begin
      oe_lo_run <= !mem_oe_n ? bump(oe_lo_run) : 8'd0;
      oe_hi_run <=  mem_oe_n ? bump(oe_hi_run) : 8'd0;
      we_lo_run <= !mem_we_n ? bump(we_lo_run) : 8'd0;
      desel_run <= !selected ? bump(desel_run) : 8'd0;
    end
  end

  assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));
  assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (oe_lo_run >= 8'(RD_CYC)));
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_run >= 8'(WR_CYC)));
  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_run >= 8'(HZ_CYC)));
  assert_write_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (selected && mem_oe_n && mem_dq_oe));
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));
  assert_stby_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |-> !req_ready);
  assert_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> (desel_run >= 8'(RC_CYC)));
  assert_single_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_async_ctrl sram_async_chk #(
  .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .HZ_CYC(HZ_CYC), .RC_CYC(RC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int CLK_NS = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_N = mx(mx(cyc(45), cyc(20)), cyc(45));
  localparam int WR_N = mx(mx(cyc(35), cyc(35)), mx(cyc(25), cyc(45)));
  localparam int HZ_N = cyc(15);
  localparam int RC_N = cyc(45);

  logic        clk, rst_n, stby_req, req_valid, req_ready, req_write, rsp_valid;
  logic [16:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_data, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  int m_total = 0, m_bad = 0;
  int wd_bad = 0;
  bit done = 0;

  logic [7:0]  shadow [logic [16:0]];
  logic [7:0]  mdl    [logic [16:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total + m_total + wd_bad, bad + m_bad + wd_bad);
  endtask

  function automatic logic [7:0] dat_of(input logic [16:0] a, input logic [7:0] salt);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ salt;
  endfunction

  // Memory model: returns garbage until a read has been open for RD_N cycles
  int  rd_run, wlen;
  bit  prev_wr;
  always @(negedge clk) begin
    bit sel, wr;
    if (!rst_n) begin
      rd_run = 0; wlen = 0; prev_wr = 0; mem_dq_i = 8'hC3;
    end else begin
      sel = !mem_ce_n && mem_ce;
      if (sel && !mem_oe_n && mem_we_n) rd_run++; else rd_run = 0;
      if (mem_dq_oe && sel && !mem_oe_n) begin
        m_total++; m_bad++;
        $display("FAIL R5 bus contention actual=1 expected=0");
      end
      wr = sel && !mem_we_n;
      if (wr) wlen++;
      else if (prev_wr) begin
        m_total += 2;
        if (!mem_dq_oe) begin
          m_bad++;
          $display("FAIL R4 data not driven at write end actual=0 expected=1");
        end else mdl[mem_addr] = mem_dq_o;
        if (wlen != WR_N) begin
          m_bad++;
          $display("FAIL R4 write pulse cycles actual=%0d expected=%0d", wlen, WR_N);
        end
        wlen = 0;
      end
      prev_wr = wr;
      if (rd_run >= RD_N) mem_dq_i = mdl.exists(mem_addr) ? mdl[mem_addr] : 8'h3C;
      else                mem_dq_i = 8'hC3;
    end
  end

  function automatic bit desel();
    return mem_ce_n && !mem_ce;
  endfunction

  task automatic issue(input logic w, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int n;
    issue(1'b1, a, d);
    shadow[a] = d;
    n = 0;
    do begin
      @(negedge clk);
      if (!req_ready) n++;
    end while (!req_ready && n < 50);
    chk(n == HZ_N + WR_N + 1, "R4 write occupancy", n, HZ_N + WR_N + 1);
  endtask

  task automatic wait_rsp(input logic [16:0] a);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rsp_valid && n < 50);
    chk(n == RD_N + 1, "R3 read latency", n, RD_N + 1);
    chk(rsp_data == shadow[a], "R12 read data", rsp_data, shadow[a]);
    @(negedge clk);
    chk(!rsp_valid, "R11 response one cycle", rsp_valid, 0);
  endtask

  task automatic do_read(input logic [16:0] a);
    issue(1'b0, a, 8'h00);
    wait_rsp(a);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      wd_bad = 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [16:0] a;
    rst_n = 0; stby_req = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(desel() && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins in reset", 0, 1);
    chk(!req_ready && !rsp_valid, "R1 handshake in reset", req_ready, 0);
    rst_n = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!req_ready) chk(desel(), "R1 deselected during recovery", 0, 1);
    end while (!req_ready && n < 50);
    chk(n == RC_N, "R1 ready after reset", n, RC_N);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R2 idle pins quiet", 0, 1);

    // Address sweep: patterned plus walking ones
    for (int i = 0; i < 64; i++) begin
      a = 17'(i * 2029 + 77);
      do_write(a, dat_of(a, 8'h5A));
    end
    for (int b = 0; b < 17; b++) do_write(17'(1) << b, dat_of(17'(1) << b, 8'hA3));
    for (int i = 0; i < 64; i++) do_read(17'(i * 2029 + 77));
    for (int b = 0; b < 17; b++) do_read(17'(1) << b);

    // Alternating write then read of the same location
    for (int i = 0; i < 32; i++) begin
      a = 17'(i * 4099 + 3);
      do_write(a, dat_of(a, 8'(i * 37)));
      do_read(a);
    end

    // R8: standby from idle, request held meanwhile
    @(negedge clk);
    stby_req = 1'b1;
    #1 chk(!req_ready, "R8 ready drops with standby", req_ready, 0);
    @(negedge clk);
    chk(desel(), "R8 deselected in standby", 0, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'(77); req_wdata = 8'h00;
    repeat (6) begin
      @(negedge clk);
      chk(!req_ready && desel() && mem_we_n && !rsp_valid, "R8 request ignored in standby", 0, 1);
    end
    stby_req = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!req_ready) chk(desel(), "R10 deselected during recovery", 0, 1);
    end while (!req_ready && n < 50);
    chk(n == RC_N + 1, "R10 ready after standby exit", n, RC_N + 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    wait_rsp(17'(77));

    // R9: standby requested during a write
    a = 17'h1ABCD;
    issue(1'b1, a, 8'h96);
    shadow[a] = 8'h96;
    stby_req = 1'b1;
    repeat (HZ_N + WR_N + 4) @(negedge clk);
    chk(desel(), "R9 deselected after write", 0, 1);
    chk(mdl.exists(a) && mdl[a] == 8'h96, "R9 write completed before standby",
        mdl.exists(a) ? int'(mdl[a]) : -1, 8'h96);
    stby_req = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ready && n < 50);
    chk(n == RC_N + 1, "R10 ready after second standby", n, RC_N + 1);
    do_read(a);

    done = 1;
    summary();
    $finish;
  end
endmodule